// File: doc/BRIEF.md
# Violation-learning mode selector

This block is a small learning table kept beside the memory directory of a multiprocessor that runs threads speculatively. It records the cache lines that caused cross-thread dependence violations. Each tracked line holds a conservativeness level. The level rises each time another violation is seen on that line, and it falls with a periodic age tick. On every cycle the table answers a lookup by line address with the avoidance mode that later accesses to that line should use.

The modes form an ordered ladder. The lowest rung is plain speculation. The next rungs are delayed per-word disambiguation, last-value prediction, stalling until a predecessor commits, and finally stalling until the consumer is no longer speculative. Only a real violation with a squash can bring a line into the table. A potential violation only pushes up a line that is already tracked. Aging walks every line back down, and a line that reaches plain speculation leaves the table. When all slots are in use, the least-escalated entry is replaced, and among equals the one allocated earliest goes.

Top module: `mlad_table`

## Requirements
- R1: While reset is asserted, and right after it, every slot is empty and every lookup returns mode 0.
- R2: Mode encoding is 0 plain speculation, 1 delayed disambiguation, 2 value prediction, 3 stall-until-commit, 4 stall-until-safe. A lookup is combinational on the registered table. A hit returns the slot's mode and a miss returns 0.
- R3: A real violation (`evt_valid_i`=1, `evt_real_i`=1) on an untracked line allocates a slot at mode 1, which is visible on the cycle after the clock edge.
- R4: Any violation, real or potential (`evt_real_i`=0), on a tracked line raises that line's mode by exactly one.
- R5: A potential violation on an untracked line is ignored: no slot is created and the lookup stays 0.
- R6: An age tick lowers every tracked line's mode by one. A line whose mode reaches 0 is freed, and its lookup returns 0.
- R7: When an age tick and an event come in the same cycle, the age tick is applied first and the event is applied to the aged table. A line at mode 1 that also takes a real violation ends at mode 1, and with a potential violation it is freed.
- R8: While any slot is free, a new allocation takes a free slot and evicts nothing.
- R9: When every slot is in use, a new allocation replaces the slot with the lowest mode, and among equal modes the one allocated earliest.
- R10: A mode saturates at 4 and the lookup never reports a value above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| age_tick_i | input | 1 | Age pulse, lowers every tracked line by one |
| evt_valid_i | input | 1 | A violation event is present this cycle |
| evt_real_i | input | 1 | 1 = real violation with squash, 0 = potential violation |
| evt_line_i | input | LINE_W | Line address of the event |
| lk_line_i | input | LINE_W | Line address to look up |
| lk_mode_o | output | 3 | Selected avoidance mode for `lk_line_i` |

## Verification
The ladder is driven with repeated real and potential violations on a single line, up to saturation. That run separates allocation from escalation and confirms that a potential violation is ignored unless the line is already tracked. Age ticks are applied alone and together with events on the same cycle. A line at mode 1 that takes age plus a real violation must stay at 1, while age plus a potential violation must free it, which shows the order in which the two are applied. The table is then filled completely with equal modes plus one raised line. A sequence of new allocations must evict the earliest equal-mode line, pass over the raised one, and finally prefer a lower mode over an older line.

// File: rtl/mlad_pkg.sv
package mlad_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_PLAIN      = 3'd0,
        MODE_DELAY_DIS  = 3'd1,
        MODE_VAL_PRED   = 3'd2,
        MODE_STALL_REL  = 3'd3,
        MODE_STALL_WAIT = 3'd4
    } spec_mode_e;

    localparam logic [MODE_W-1:0] MODE_TOP = MODE_STALL_WAIT;

endpackage

// File: rtl/mlad_cam.sv
module mlad_cam #(
    parameter int N      = 16,
    parameter int LINE_W = 24,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             vld_i,
    input  logic [N-1:0][LINE_W-1:0] lines_i,
    input  logic [LINE_W-1:0]        key_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         idx_o
);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld_i[g] && (lines_i[g] == key_i);
    end

    // A line is held by at most one slot; the encoder picks the lowest set bit.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/mlad_victim.sv
module mlad_victim #(
    parameter int N      = 16,
    parameter int MODE_W = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             vld_i,
    input  logic [N-1:0][MODE_W-1:0] mode_i,
    input  logic [N-1:0][IDX_W-1:0]  rank_i,
    output logic [IDX_W-1:0]         idx_o
);

    localparam int KEY_W = MODE_W + IDX_W;

    logic [N-1:0][KEY_W-1:0] key;

    // Sort key: mode first, then allocation rank (lower = earlier).
    for (genvar g = 0; g < N; g++) begin : g_key
        assign key[g] = {mode_i[g], rank_i[g]};
    end

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] min_idx;
    logic [KEY_W-1:0] min_key;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        min_idx = '0;
        min_key = key[0];
        for (int i = 1; i < N; i++) begin
            if (key[i] < min_key) begin
                min_key = key[i];
                min_idx = IDX_W'(i);
            end
        end
    end

    assign idx_o = any_free ? free_idx : min_idx;

endmodule

// File: rtl/mlad_table.sv
module mlad_table #(
    parameter int N      = 16,
    parameter int LINE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              age_tick_i,
    input  logic              evt_valid_i,
    input  logic              evt_real_i,
    input  logic [LINE_W-1:0] evt_line_i,
    input  logic [LINE_W-1:0] lk_line_i,
    output logic [2:0]        lk_mode_o
);

    import mlad_pkg::*;

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] RANK_NEW = IDX_W'(N - 1);

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic [MODE_W-1:0] mode;
        logic [IDX_W-1:0]  rank;
    } slot_t;

    slot_t [N-1:0] tab_d, tab_q;

    // Flattened views of the registered and the aged table.
    logic [N-1:0]             cur_vld;
    logic [N-1:0]             aged_vld;
    logic [N-1:0][LINE_W-1:0] cur_line;
    logic [N-1:0][MODE_W-1:0] aged_mode;
    logic [N-1:0][IDX_W-1:0]  cur_rank;

    for (genvar g = 0; g < N; g++) begin : g_view
        logic expire;
        assign expire       = age_tick_i && (tab_q[g].mode <= MODE_DELAY_DIS);
        assign cur_vld[g]   = tab_q[g].vld;
        assign cur_line[g]  = tab_q[g].line;
        assign cur_rank[g]  = tab_q[g].rank;
        assign aged_vld[g]  = tab_q[g].vld && !expire;
        assign aged_mode[g] = !aged_vld[g] ? MODE_PLAIN
                            : (age_tick_i ? tab_q[g].mode - 1'b1 : tab_q[g].mode);
    end

    // Event lookup against the aged table (age first, then event).
    logic             evt_hit;
    logic [IDX_W-1:0] evt_idx;

    mlad_cam #(.N(N), .LINE_W(LINE_W)) u_evt_cam (
        .vld_i   (aged_vld),
        .lines_i (cur_line),
        .key_i   (evt_line_i),
        .hit_o   (evt_hit),
        .idx_o   (evt_idx)
    );

    logic [IDX_W-1:0] vic_idx;

    mlad_victim #(.N(N), .MODE_W(MODE_W)) u_victim (
        .vld_i  (aged_vld),
        .mode_i (aged_mode),
        .rank_i (cur_rank),
        .idx_o  (vic_idx)
    );

    // Read port against the registered table.
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;

    mlad_cam #(.N(N), .LINE_W(LINE_W)) u_lk_cam (
        .vld_i   (cur_vld),
        .lines_i (cur_line),
        .key_i   (lk_line_i),
        .hit_o   (lk_hit),
        .idx_o   (lk_idx)
    );

    assign lk_mode_o = lk_hit ? tab_q[lk_idx].mode : MODE_PLAIN;

    always_comb begin
        logic [IDX_W-1:0] old_rank;
        tab_d = tab_q;
        old_rank = tab_q[vic_idx].rank;

        for (int i = 0; i < N; i++) begin
            tab_d[i].vld  = aged_vld[i];
            tab_d[i].mode = aged_mode[i];
        end

        if (evt_valid_i) begin
            if (evt_hit) begin
                if (aged_mode[evt_idx] < MODE_TOP)
                    tab_d[evt_idx].mode = aged_mode[evt_idx] + 1'b1;
            end else if (evt_real_i) begin
                // Ranks stay a permutation: the new slot becomes youngest.
                for (int i = 0; i < N; i++) begin
                    if (tab_q[i].rank > old_rank)
                        tab_d[i].rank = tab_q[i].rank - 1'b1;
                end
                tab_d[vic_idx].vld  = 1'b1;
                tab_d[vic_idx].line = evt_line_i;
                tab_d[vic_idx].mode = MODE_DELAY_DIS;
                tab_d[vic_idx].rank = RANK_NEW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                tab_q[i].vld  <= 1'b0;
                tab_q[i].line <= '0;
                tab_q[i].mode <= MODE_PLAIN;
                tab_q[i].rank <= IDX_W'(i);
            end
        end else begin
            tab_q <= tab_d;
        end
    end

endmodule

// File: rtl/mlad_checker.sv
module mlad_checker #(
    parameter int LINE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              age_tick_i,
    input logic              evt_valid_i,
    input logic              evt_real_i,
    input logic [LINE_W-1:0] lk_line_i,
    input logic [2:0]        lk_mode_o
);

    // R10: the reported mode never leaves the ladder.
    a_r10_mode_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        lk_mode_o <= 3'd4);

    // R1: the first cycle out of reset shows an empty table.
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> lk_mode_o == 3'd0);

    // R4: a tracked line climbs by exactly one step per cycle.
    a_r4_rise_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lk_line_i) && lk_mode_o > $past(lk_mode_o))
        |-> lk_mode_o == $past(lk_mode_o) + 3'd1);

    // R5: only a real violation can bring a line into the table.
    a_r5_no_alloc_without_real: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lk_line_i) && $past(lk_mode_o) == 3'd0
         && !$past(evt_valid_i && evt_real_i))
        |-> lk_mode_o == 3'd0);

    // R6: an age tick with no event lowers a tracked line by one.
    a_r6_age_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lk_line_i) && $past(age_tick_i) && !$past(evt_valid_i)
         && $past(lk_mode_o) != 3'd0)
        |-> lk_mode_o == $past(lk_mode_o) - 3'd1);

    // R6: without an age tick a line drops only through eviction, to 0.
    a_r6_no_fall_without_age: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lk_line_i) && !$past(age_tick_i) && lk_mode_o < $past(lk_mode_o))
        |-> lk_mode_o == 3'd0);

endmodule

bind mlad_table mlad_checker #(.LINE_W(LINE_W)) u_mlad_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .age_tick_i  (age_tick_i),
    .evt_valid_i (evt_valid_i),
    .evt_real_i  (evt_real_i),
    .lk_line_i   (lk_line_i),
    .lk_mode_o   (lk_mode_o)
);

// File: tb/mlad_table_bench.sv
module mlad_table_bench;

    localparam int LINE_W = 24;
    localparam int NSLOT  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              age_tick_i = 1'b0;
    logic              evt_valid_i = 1'b0;
    logic              evt_real_i = 1'b0;
    logic [LINE_W-1:0] evt_line_i = '0;
    logic [LINE_W-1:0] lk_line_i = '0;
    logic [2:0]        lk_mode_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    mlad_table #(.N(NSLOT), .LINE_W(LINE_W)) u_mlad_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .age_tick_i  (age_tick_i),
        .evt_valid_i (evt_valid_i),
        .evt_real_i  (evt_real_i),
        .evt_line_i  (evt_line_i),
        .lk_line_i   (lk_line_i),
        .lk_mode_o   (lk_mode_o)
    );

    typedef struct packed {
        logic       age;
        logic       ev;
        logic       rl;
        logic [7:0] evl;
        logic [7:0] lkl;
        logic [2:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{1'b0, 1'b1, 1'b1, 8'h10, 8'h10, 3'd1, 4'd3 },  // R3 allocate at 1
        '{1'b0, 1'b1, 1'b1, 8'h10, 8'h10, 3'd2, 4'd4 },  // R4 real raise
        '{1'b0, 1'b1, 1'b0, 8'h10, 8'h10, 3'd3, 4'd4 },  // R4 potential raise
        '{1'b0, 1'b1, 1'b1, 8'h10, 8'h10, 3'd4, 4'd4 },  // R4 reach top
        '{1'b0, 1'b1, 1'b1, 8'h10, 8'h10, 3'd4, 4'd10},  // R10 saturate
        '{1'b0, 1'b1, 1'b0, 8'h22, 8'h22, 3'd0, 4'd5 },  // R5 ignored
        '{1'b0, 1'b0, 1'b0, 8'h00, 8'h10, 3'd4, 4'd2 },  // R2 hit
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h10, 3'd3, 4'd6 },  // R6 age down
        '{1'b0, 1'b1, 1'b1, 8'h33, 8'h33, 3'd1, 4'd3 },  // R3 second line
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h33, 3'd0, 4'd6 },  // R6 freed
        '{1'b0, 1'b0, 1'b0, 8'h00, 8'h10, 3'd2, 4'd6 },  // R6 other line aged
        '{1'b1, 1'b1, 1'b1, 8'h10, 8'h10, 3'd2, 4'd7 },  // R7 age then raise
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h10, 3'd1, 4'd6 },  // R6 down to 1
        '{1'b1, 1'b1, 1'b0, 8'h10, 8'h10, 3'd0, 4'd7 },  // R7 freed, potential lost
        '{1'b0, 1'b1, 1'b1, 8'h44, 8'h44, 3'd1, 4'd3 },  // R3 new line
        '{1'b1, 1'b1, 1'b1, 8'h44, 8'h44, 3'd1, 4'd7 }   // R7 freed then realloc
    };

    function automatic logic [LINE_W-1:0] ext(input logic [11:0] a);
        return {{(LINE_W-12){1'b0}}, a};
    endfunction

    task automatic check(input logic [2:0] exp, input string req, input string what);
        n_checks++;
        if (lk_mode_o !== exp) begin
            n_fail++;
            $display("FAIL %s %s: mode=%0d expected=%0d", req, what, lk_mode_o, exp);
        end
    endtask

    task automatic step(input logic age, input logic ev, input logic rl,
                        input logic [11:0] evl, input logic [11:0] lkl);
        @(negedge clk);
        age_tick_i  = age;
        evt_valid_i = ev;
        evt_real_i  = rl;
        evt_line_i  = ext(evl);
        lk_line_i   = ext(lkl);
        @(posedge clk);
        #2;
        age_tick_i  = 1'b0;
        evt_valid_i = 1'b0;
        evt_real_i  = 1'b0;
    endtask

    task automatic look(input logic [11:0] l, input logic [2:0] exp,
                        input string req, input string what);
        @(negedge clk);
        lk_line_i = ext(l);
        #1;
        check(exp, req, what);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state, probed while reset is still held
        lk_line_i = ext(12'h010);
        #1;
        check(3'd0, "R1", "empty during reset");
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(3'd0, "R1", "empty after reset");

        for (int i = 0; i < 16; i++) begin
            step(VECS[i].age, VECS[i].ev, VECS[i].rl,
                 {4'h0, VECS[i].evl}, {4'h0, VECS[i].lkl});
            check(VECS[i].exp, $sformatf("R%0d", VECS[i].req),
                  $sformatf("vector %0d", i));
        end

        // R1: reset clears a tracked line
        do_reset();
        look(12'h044, 3'd0, "R1", "line cleared by reset");

        // R8: fill all slots, nothing evicted
        for (int i = 0; i < NSLOT; i++) begin
            step(1'b0, 1'b1, 1'b1, 12'h100 + 12'(i), 12'h100 + 12'(i));
        end
        look(12'h100, 3'd1, "R8", "first fill line kept");
        look(12'h10F, 3'd1, "R8", "last fill line present");
        step(1'b0, 1'b1, 1'b0, 12'h100, 12'h100);
        check(3'd2, "R4", "raise 0x100");

        // R9: ties go to the earliest allocation; the raised line is spared
        step(1'b0, 1'b1, 1'b1, 12'h200, 12'h200);
        check(3'd1, "R9", "new line 0x200");
        look(12'h101, 3'd0, "R9", "earliest equal-mode line evicted");
        look(12'h100, 3'd2, "R9", "higher mode kept");
        look(12'h102, 3'd1, "R9", "next oldest kept");
        step(1'b0, 1'b1, 1'b1, 12'h201, 12'h201);
        look(12'h102, 3'd0, "R9", "second eviction oldest");
        look(12'h200, 3'd1, "R9", "young line kept");

        // R9: lower mode beats age
        step(1'b0, 1'b1, 1'b0, 12'h103, 12'h103);
        check(3'd2, "R4", "raise 0x103");
        step(1'b0, 1'b1, 1'b1, 12'h202, 12'h202);
        look(12'h103, 3'd2, "R9", "older but higher mode kept");
        look(12'h104, 3'd0, "R9", "lowest mode oldest evicted");
        look(12'h202, 3'd1, "R9", "line 0x202 in");

        // R6 with a full table: mode 1 lines freed, raised lines drop to 1
        step(1'b1, 1'b0, 1'b0, 12'h000, 12'h100);
        check(3'd1, "R6", "0x100 aged to 1");
        look(12'h10F, 3'd0, "R6", "mode 1 line freed");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule